// File: doc/BRIEF.md
# Receive Packet Buffer with Per-Packet Status

This block sits between a receive MAC and a host. Incoming frames arrive as a byte stream framed by a start strobe and an end strobe. The end strobe carries a 4-bit error code. Bytes go into a shared circular byte store. Each finished frame leaves a 16-bit status word in a small queue. The host always sees the status word of the oldest frame and the next unread byte of that frame. The host takes bytes one at a time with a read strobe. A discard strobe drops whatever is left of the oldest frame, together with its status, in a single cycle.

The block also bounds how much it accepts. The number of finished frames held at once is capped, and the byte store has a fixed size. Both limits raise diagnostic flags. A read past the bytes that exist for the oldest frame is treated as a fatal host error. It raises a sticky underrun flag and an adapter-failure output, and only a receive reset clears them. Within one frame, the MAC drives start, data bytes and end on separate cycles.

Status word layout:
- bit 15 is the incomplete flag.
- bits 14..11 are the error code. Bit 14 set means an error. 1000 = overrun, 1001 = oversize, 1011 = runt, 1100 = alignment, 1101 = CRC, 0010 = dribble bits, which is not an error.
- bits 10..0 are the byte count.

Top module: `rx_packet_fifo`

## Requirements
- R1: After reset, the status word is 0x8000 and every flag output and `rxComplete` are low.
- R2: For a finished oldest frame, the status word has bit 15 = 0, bits 14..11 = the code given with the end strobe, and bits 10..0 = the stored byte count. `rdData` presents that frame's bytes in arrival order, one per read strobe.
- R3: While no finished frame is held, the status word is {1, 0000, bytes received so far by the frame in progress}, or 0x8000 when no frame is in progress. `receiving` is high from an accepted start until its end.
- R4: A frame longer than MAX_LEN (1514) bytes keeps only its first MAX_LEN bytes and finishes with code 1001 and count MAX_LEN. A frame of exactly MAX_LEN bytes keeps the code it was given.
- R5: While MAX_PKTS (8) finished frames are held, `statusOverrun` is high and a new start is refused: `receiving` stays low, and neither bytes nor status are stored. The flag drops after one discard.
- R6: While the byte store is full, `rxOverrun` is high. The byte that met the full store and every later byte of that frame are dropped, and the frame finishes with code 1000 and the count of bytes stored. The flag drops once a byte is read.
- R7: A read strobe when the oldest frame has no unread byte sets `rxUnderrun` and `adapterFail`. Both stay set until a receive reset. While they are set, read strobes remove nothing.
- R8: A discard removes the unread bytes and the status of the oldest finished frame in one cycle, so the next frame's status and first byte appear on the following cycle. A discard with no finished frame has no effect.
- R9: `rxComplete` is high exactly when at least one finished frame is held.
- R10: A receive reset empties the buffer, abandons a frame in progress and clears all flags in one cycle. An end strobe that follows it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxReset | input | 1 | Synchronous receive reset |
| macStart | input | 1 | Frame start strobe |
| macByteValid | input | 1 | A data byte is present on macData |
| macData | input | 8 | Received data byte |
| macEnd | input | 1 | Frame end strobe |
| macErrCode | input | 4 | Error code sampled with macEnd |
| hostRead | input | 1 | Take one byte of the oldest frame |
| hostDiscard | input | 1 | Drop the oldest finished frame |
| statusWord | output | 16 | Status of the oldest frame |
| rdData | output | 8 | Next unread byte of the oldest frame |
| receiving | output | 1 | A frame is being written |
| rxOverrun | output | 1 | Byte store full |
| statusOverrun | output | 1 | Frame-count limit reached |
| rxUnderrun | output | 1 | Sticky read-past-end flag |
| adapterFail | output | 1 | Fatal error indication |
| rxComplete | output | 1 | At least one finished frame held |

## Verification
A wrong read pointer shows up on `rdData` at the very next byte the host compares. The bench checks every byte against a value computed from the frame's seed and index. A wrong status-queue pointer or count shows up as a wrong status word on the cycle right after a discard or commit. A miscounted per-frame read offset shows up at the frame boundary, where `rxUnderrun` would rise one byte early or late. Random frame lengths and random partial reads before each discard make that boundary land at many different places in the byte store.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W = 11;

  typedef struct packed {
    logic             incomplete;
    logic [3:0]       errCode;
    logic [LEN_W-1:0] byteCount;
  } rxStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic skip;
    logic clear;
  } fifoCmd_t;

  localparam logic [3:0] CODE_OVERRUN  = 4'b1000;
  localparam logic [3:0] CODE_OVERSIZE = 4'b1001;
endpackage

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCmd_t      cmd,
  input  logic [7:0]    wrData,
  input  logic [CW-1:0] skipLen,
  output logic [7:0]    rdData,
  output logic [CW-1:0] used,
  output logic          full
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [CW-1:0] addCnt;
  logic [CW-1:0] subCnt;

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_comb begin
    addCnt = CW'(cmd.push);
    subCnt = cmd.pop ? CW'(1) : (cmd.skip ? skipLen : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + AW'(1);
      if (cmd.pop) rdPtr <= rdPtr + AW'(1);
      else if (cmd.skip) rdPtr <= rdPtr + skipLen[AW-1:0];
      used <= used + addCnt - subCnt;
    end
  end

  assign rdData = mem[rdPtr];
  assign full   = (used == CW'(DEPTH));
endmodule

// File: rtl/rxf_control.sv
module rxf_control
  import rxf_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int MAX_PKTS = 8,
  parameter int MAX_LEN  = 1514,
  localparam int CW    = $clog2(DEPTH) + 1,
  localparam int PW    = $clog2(MAX_PKTS),
  localparam int CNT_W = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxReset,
  input  logic          macStart,
  input  logic          macByteValid,
  input  logic          macEnd,
  input  logic [3:0]    macErrCode,
  input  logic          hostRead,
  input  logic          hostDiscard,
  input  logic [CW-1:0] fifoUsed,
  input  logic          fifoFull,
  output fifoCmd_t      cmd,
  output logic [CW-1:0] skipLen,
  output logic [15:0]   statusWord,
  output logic          receiving,
  output logic          rxUnderrun,
  output logic          statusOverrun,
  output logic          rxOverrun,
  output logic          rxComplete
);
  rxStat_t          stQ [MAX_PKTS];
  logic [PW-1:0]    stWr, stRd;
  logic [CNT_W-1:0] pktCount;
  logic             inPkt, dropRest, curOvr, curBig;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] headRead;
  logic             underrun;

  logic    haveDone, statFull;
  logic    startOk, endOk, byteIn, byteTake, byteOverrun, byteTooLong;
  logic    discardOk, readOk, readBad;
  rxStat_t headStat, commitStat;
  logic [CW-1:0] remain;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(MAX_PKTS - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    haveDone    = (pktCount != '0);
    statFull    = (pktCount == CNT_W'(MAX_PKTS));
    headStat    = stQ[stRd];
    startOk     = macStart && !inPkt && !statFull;
    endOk       = macEnd && inPkt;
    byteIn      = macByteValid && inPkt && !macEnd && !dropRest;
    byteOverrun = byteIn && fifoFull;
    byteTooLong = byteIn && !fifoFull && (curLen == LEN_W'(MAX_LEN));
    byteTake    = byteIn && !fifoFull && (curLen != LEN_W'(MAX_LEN));
    remain      = haveDone ? (CW'(headStat.byteCount) - CW'(headRead)) : fifoUsed;
    discardOk   = hostDiscard && haveDone;
    readOk      = hostRead && !hostDiscard && !underrun && (remain != '0);
    readBad     = hostRead && !hostDiscard && !underrun && (remain == '0);

    commitStat.incomplete = 1'b0;
    commitStat.byteCount  = curLen;
    if (curOvr)      commitStat.errCode = CODE_OVERRUN;
    else if (curBig) commitStat.errCode = CODE_OVERSIZE;
    else             commitStat.errCode = macErrCode;

    cmd.push  = byteTake && !rxReset;
    cmd.pop   = readOk && !rxReset;
    cmd.skip  = discardOk && !rxReset;
    cmd.clear = rxReset;
    skipLen   = remain;

    if (haveDone) statusWord = headStat;
    else          statusWord = {1'b1, 4'b0000, inPkt ? curLen : LEN_W'(0)};
  end

  always_ff @(posedge clk) begin
    if (endOk) stQ[stWr] <= commitStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stWr <= '0; stRd <= '0; pktCount <= '0;
      inPkt <= 1'b0; dropRest <= 1'b0; curOvr <= 1'b0; curBig <= 1'b0;
      curLen <= '0; headRead <= '0; underrun <= 1'b0;
    end else if (rxReset) begin
      stWr <= '0; stRd <= '0; pktCount <= '0;
      inPkt <= 1'b0; dropRest <= 1'b0; curOvr <= 1'b0; curBig <= 1'b0;
      curLen <= '0; headRead <= '0; underrun <= 1'b0;
    end else begin
      if (startOk) begin
        inPkt <= 1'b1; dropRest <= 1'b0; curOvr <= 1'b0; curBig <= 1'b0;
        curLen <= '0;
      end else if (endOk) begin
        inPkt <= 1'b0;
        stWr  <= nextPtr(stWr);
      end
      if (byteTake) curLen <= curLen + LEN_W'(1);
      if (byteOverrun) begin curOvr <= 1'b1; dropRest <= 1'b1; end
      if (byteTooLong) begin curBig <= 1'b1; dropRest <= 1'b1; end

      if (discardOk) begin
        stRd     <= nextPtr(stRd);
        headRead <= '0;
      end else if (readOk) begin
        headRead <= headRead + LEN_W'(1);
      end
      if (readBad) underrun <= 1'b1;
      pktCount <= pktCount + CNT_W'(endOk) - CNT_W'(discardOk);
    end
  end

  assign receiving     = inPkt;
  assign rxUnderrun    = underrun;
  assign statusOverrun = statFull;
  assign rxOverrun     = fifoFull;
  assign rxComplete    = haveDone;
endmodule

// File: rtl/rx_packet_fifo.sv
module rx_packet_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int MAX_PKTS = 8,
  parameter int MAX_LEN  = 1514,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxReset,
  input  logic        macStart,
  input  logic        macByteValid,
  input  logic [7:0]  macData,
  input  logic        macEnd,
  input  logic [3:0]  macErrCode,
  input  logic        hostRead,
  input  logic        hostDiscard,
  output logic [15:0] statusWord,
  output logic [7:0]  rdData,
  output logic        receiving,
  output logic        rxOverrun,
  output logic        statusOverrun,
  output logic        rxUnderrun,
  output logic        adapterFail,
  output logic        rxComplete
);
  fifoCmd_t      fifoCmd;
  logic [CW-1:0] skipLen;
  logic [CW-1:0] fifoUsed;
  logic          fifoFull;

  rxf_control #(.DEPTH(DEPTH), .MAX_PKTS(MAX_PKTS), .MAX_LEN(MAX_LEN)) u_control (
    .clk(clk), .rstN(rstN), .rxReset(rxReset),
    .macStart(macStart), .macByteValid(macByteValid), .macEnd(macEnd),
    .macErrCode(macErrCode), .hostRead(hostRead), .hostDiscard(hostDiscard),
    .fifoUsed(fifoUsed), .fifoFull(fifoFull), .cmd(fifoCmd), .skipLen(skipLen),
    .statusWord(statusWord), .receiving(receiving), .rxUnderrun(rxUnderrun),
    .statusOverrun(statusOverrun), .rxOverrun(rxOverrun), .rxComplete(rxComplete)
  );

  rxf_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .cmd(fifoCmd), .wrData(macData), .skipLen(skipLen),
    .rdData(rdData), .used(fifoUsed), .full(fifoFull)
  );

  assign adapterFail = rxUnderrun;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int MAX_LEN = 1514
) (
  input logic        clk,
  input logic        rstN,
  input logic        rxReset,
  input logic [15:0] statusWord,
  input logic        receiving,
  input logic        statusOverrun,
  input logic        rxUnderrun,
  input logic        adapterFail,
  input logic        rxComplete
);
  // R9: a held finished frame is never reported as incomplete
  a_r9_complete_vs_flag: assert property (@(posedge clk) disable iff (!rstN)
    rxComplete != statusWord[15]);

  // R7: underrun is sticky until a receive reset
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxUnderrun && !rxReset) |=> rxUnderrun);

  // R7: the failure output follows the underrun condition
  a_r7_fail_tracks: assert property (@(posedge clk) disable iff (!rstN)
    adapterFail == rxUnderrun);

  // R4: a reported count never exceeds the length limit
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[10:0] <= 11'(MAX_LEN));

  // R5: the frame-count limit implies finished frames are held
  a_r5_full_has_frames: assert property (@(posedge clk) disable iff (!rstN)
    statusOverrun |-> rxComplete);

  // R10: a receive reset empties everything on the next cycle
  a_r10_reset_empties: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |=> (statusWord == 16'h8000 && !rxComplete && !rxUnderrun && !receiving));

  // R3: idle and empty reads as the empty status
  a_r3_idle_status: assert property (@(posedge clk) disable iff (!rstN)
    (!receiving && !rxComplete) |-> statusWord == 16'h8000);
endmodule

bind rx_packet_fifo rxf_checker #(.MAX_LEN(MAX_LEN)) u_rxfChecker (
  .clk(clk), .rstN(rstN), .rxReset(rxReset), .statusWord(statusWord),
  .receiving(receiving), .statusOverrun(statusOverrun), .rxUnderrun(rxUnderrun),
  .adapterFail(adapterFail), .rxComplete(rxComplete)
);

// File: tb/tb_rx_packet_fifo.sv
module tb_rx_packet_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxReset = 1'b0, macStart = 1'b0, macByteValid = 1'b0, macEnd = 1'b0;
  logic [7:0] macData = '0;
  logic [3:0] macErrCode = '0;
  logic hostRead = 1'b0, hostDiscard = 1'b0;
  logic [15:0] statusWord;
  logic [7:0] rdData;
  logic receiving, rxOverrun, statusOverrun, rxUnderrun, adapterFail, rxComplete;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [3:0] codeSet [5] = '{4'b0000, 4'b1011, 4'b1100, 4'b1101, 4'b0010};
  int         mLen[$];
  logic [3:0] mCode[$];
  logic [7:0] mBase[$];

  rx_packet_fifo dut (
    .clk(clk), .rstN(rstN), .rxReset(rxReset), .macStart(macStart),
    .macByteValid(macByteValid), .macData(macData), .macEnd(macEnd),
    .macErrCode(macErrCode), .hostRead(hostRead), .hostDiscard(hostDiscard),
    .statusWord(statusWord), .rdData(rdData), .receiving(receiving),
    .rxOverrun(rxOverrun), .statusOverrun(statusOverrun), .rxUnderrun(rxUnderrun),
    .adapterFail(adapterFail), .rxComplete(rxComplete)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] pktByte(input logic [7:0] base, input int idx);
    return base + 8'(idx * 13);
  endfunction

  function automatic logic [15:0] expStat(input logic [3:0] code, input int len);
    return {1'b0, code, 11'(len)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) macStart = 1'b1;
    @(negedge clk) macStart = 1'b0;
  endtask
  task automatic pushByte(input logic [7:0] b);
    @(negedge clk) begin macByteValid = 1'b1; macData = b; end
    @(negedge clk) macByteValid = 1'b0;
  endtask
  task automatic pulseEnd(input logic [3:0] code);
    @(negedge clk) begin macEnd = 1'b1; macErrCode = code; end
    @(negedge clk) macEnd = 1'b0;
  endtask
  task automatic doRead();
    @(negedge clk) hostRead = 1'b1;
    @(negedge clk) hostRead = 1'b0;
  endtask
  task automatic doDiscard();
    @(negedge clk) hostDiscard = 1'b1;
    @(negedge clk) hostDiscard = 1'b0;
  endtask
  task automatic doRxReset();
    @(negedge clk) rxReset = 1'b1;
    @(negedge clk) rxReset = 1'b0;
  endtask
  task automatic sendPkt(input int len, input logic [3:0] code, input logic [7:0] base);
    pulseStart();
    for (int i = 0; i < len; i++) pushByte(pktByte(base, i));
    pulseEnd(code);
  endtask
  task automatic readCheck(input string tag, input logic [7:0] base, input int idx);
    chk(tag, 16'(rdData), 16'(pktByte(base, idx)));
    doRead();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", statusWord, 16'h8000);
    chk("R1 flags", 16'({receiving, rxOverrun, statusOverrun, rxUnderrun, adapterFail, rxComplete}), 16'h0);

    // R3 frame in progress, R8 discard with nothing finished
    pulseStart();
    for (int i = 0; i < 5; i++) pushByte(pktByte(8'h10, i));
    chk("R3 growing status", statusWord, 16'h8005);
    chk("R3 receiving", 16'(receiving), 16'h1);
    doDiscard();
    chk("R8 discard no effect status", statusWord, 16'h8005);
    chk("R8 discard no effect data", 16'(rdData), 16'(pktByte(8'h10, 0)));
    readCheck("R2 early byte0", 8'h10, 0);
    readCheck("R2 early byte1", 8'h10, 1);
    chk("R3 status after reads", statusWord, 16'h8005);
    pulseEnd(4'b1101);
    chk("R2 crc status", statusWord, 16'h6805);
    chk("R3 receiving low", 16'(receiving), 16'h0);
    chk("R9 complete", 16'(rxComplete), 16'h1);
    for (int i = 2; i < 5; i++) readCheck("R2 late byte", 8'h10, i);
    sendPkt(4, 4'b0000, 8'h40);
    chk("R2 head unchanged", statusWord, 16'h6805);
    doDiscard();
    chk("R8 next status", statusWord, expStat(4'b0000, 4));
    chk("R8 next data", 16'(rdData), 16'(pktByte(8'h40, 0)));
    doDiscard();
    chk("R9 empty status", statusWord, 16'h8000);
    chk("R9 complete low", 16'(rxComplete), 16'h0);

    // R8 discard of a partly read frame
    sendPkt(6, 4'b0010, 8'h70);
    sendPkt(3, 4'b0000, 8'hA0);
    chk("R2 dribble status", statusWord, 16'h1006);
    readCheck("R8 partial byte0", 8'h70, 0);
    readCheck("R8 partial byte1", 8'h70, 1);
    doDiscard();
    chk("R8 skip status", statusWord, expStat(4'b0000, 3));
    for (int i = 0; i < 3; i++) readCheck("R8 skip data", 8'hA0, i);
    doDiscard();

    // R7 read on empty buffer
    doRead();
    chk("R7 underrun empty", 16'(rxUnderrun), 16'h1);
    chk("R7 fail empty", 16'(adapterFail), 16'h1);
    sendPkt(2, 4'b0000, 8'h33);
    doRead();
    chk("R7 read ignored", 16'(rdData), 16'(pktByte(8'h33, 0)));
    chk("R7 still set", 16'(rxUnderrun), 16'h1);
    doRxReset();
    chk("R10 cleared underrun", 16'({rxUnderrun, adapterFail}), 16'h0);
    chk("R10 empty status", statusWord, 16'h8000);

    // R7 read past the end of a frame
    sendPkt(2, 4'b0000, 8'h55);
    readCheck("R7 byte0", 8'h55, 0);
    readCheck("R7 byte1", 8'h55, 1);
    chk("R7 not yet", 16'(rxUnderrun), 16'h0);
    doRead();
    chk("R7 past end", 16'(rxUnderrun), 16'h1);
    doRxReset();

    // R4 length limit
    sendPkt(1514, 4'b0000, 8'h01);
    chk("R4 exact limit", statusWord, 16'h05EA);
    doDiscard();
    sendPkt(1520, 4'b0000, 8'h02);
    chk("R4 oversize", statusWord, 16'h4DEA);
    chk("R4 first byte", 16'(rdData), 16'(pktByte(8'h02, 0)));
    doDiscard();
    chk("R4 emptied", statusWord, 16'h8000);

    // R6 byte store full
    sendPkt(1200, 4'b0000, 8'h11);
    pulseStart();
    for (int i = 0; i < 1000; i++) pushByte(pktByte(8'h22, i));
    chk("R6 overrun flag", 16'(rxOverrun), 16'h1);
    chk("R6 head status", statusWord, expStat(4'b0000, 1200));
    readCheck("R6 read frees", 8'h11, 0);
    chk("R6 flag clears", 16'(rxOverrun), 16'h0);
    pushByte(8'hFF);
    pulseEnd(4'b0000);
    doDiscard();
    chk("R6 overrun status", statusWord, 16'h4350);
    chk("R6 data kept", 16'(rdData), 16'(pktByte(8'h22, 0)));
    doDiscard();
    chk("R6 emptied", statusWord, 16'h8000);

    // R5 frame-count limit
    doRxReset();
    for (int p = 0; p < 8; p++) sendPkt(2, 4'b0000, 8'(p * 16));
    chk("R5 flag set", 16'(statusOverrun), 16'h1);
    pulseStart();
    chk("R5 start refused", 16'(receiving), 16'h0);
    for (int i = 0; i < 3; i++) pushByte(8'hEE);
    pulseEnd(4'b0000);
    chk("R5 head kept", statusWord, 16'h0002);
    doDiscard();
    chk("R5 flag clears", 16'(statusOverrun), 16'h0);
    for (int p = 1; p < 8; p++) begin
      chk("R5 stored status", statusWord, 16'h0002);
      chk("R5 stored data", 16'(rdData), 16'(pktByte(8'(p * 16), 0)));
      doDiscard();
    end
    chk("R5 refused frame absent", statusWord, 16'h8000);

    // R10 reset during a frame
    pulseStart();
    for (int i = 0; i < 3; i++) pushByte(8'h5A);
    doRxReset();
    chk("R10 abandon", 16'(receiving), 16'h0);
    pulseEnd(4'b0000);
    chk("R10 end ignored", statusWord, 16'h8000);
    chk("R10 complete low", 16'(rxComplete), 16'h0);

    // random frames and partial reads (R2, R8)
    for (int it = 0; it < 300; it++) begin
      if (mLen.size() == 0 || ($urandom_range(0, 1) == 0 && mLen.size() < 8)) begin
        int len = int'($urandom_range(0, 40));
        logic [3:0] code = codeSet[$urandom_range(0, 4)];
        logic [7:0] base = 8'($urandom_range(0, 255));
        sendPkt(len, code, base);
        mLen.push_back(len); mCode.push_back(code); mBase.push_back(base);
      end else begin
        int k = int'($urandom_range(0, 32'(mLen[0])));
        chk("R2 random status", statusWord, expStat(mCode[0], mLen[0]));
        for (int i = 0; i < k; i++) readCheck("R2 random data", mBase[0], i);
        doDiscard();
        void'(mLen.pop_front()); void'(mCode.pop_front()); void'(mBase.pop_front());
      end
    end
    while (mLen.size() > 0) begin
      chk("R8 drain status", statusWord, expStat(mCode[0], mLen[0]));
      doDiscard();
      void'(mLen.pop_front()); void'(mCode.pop_front()); void'(mBase.pop_front());
    end
    chk("R9 drained", 16'(rxComplete), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule